// File: doc/BRIEF.md
# Compressed Line Size Predictor

A cache line stored in compressed form occupies only some of the nine 8-byte chip slices of a memory rank. How many it occupies is recorded inside the line itself, so a read must choose how many slices to fetch before it knows. This block makes that choice. It keeps a small, fully associative table keyed by a tag: either the program counter of the load or the physical page number, whichever the integrator feeds in. Each entry holds one small saturating counter for each supported size, and the size with the strongest counter is the guess.

The lookup port returns its guess in the same cycle and has no registers on the way. If the tag is not in the table, the answer is the full nine slices. Once the line has been read, the update port receives the same kind of tag, the true slice count and the count that was guessed. It trains the matching entry, or installs a new one in place of the least recently used entry. Lookups and updates both count as uses for recency.

Top module: `size_pred`

## Requirements
- R1: After reset the table is empty, and every lookup misses (lk_hit_o = 0, lk_chips_o = 9).
- R2: A lookup whose tag is not resident drives lk_hit_o = 0 and lk_chips_o = 9.
- R3: Supported sizes are 2, 3, 4, 6 and 9 slices, carried as plain slice counts. Update inputs are rounded up to the next supported size: 0 to 2 gives 2, 5 gives 6, 7 and above gives 9. lk_chips_o only ever shows a supported size.
- R4: An update whose tag is absent installs an entry with the counter for the true size at 1 and all other counters at 0. A later lookup of that tag hits and predicts the true size.
- R5: An update to a resident tag increments the counter for the true size. A 2-bit counter stops at 3.
- R6: When the guessed size differs from the true size, the counter for the guessed size is also decremented, stopping at 0.
- R7: A hit predicts the size whose counter is highest. On equal counters the larger size wins.
- R8: A lookup and an update in the same cycle, even for the same tag, return the prediction from the state before that update.
- R9: When the table is full, an update miss evicts the entry that was used least recently, counting both lookups and updates as uses.
- R10: A lookup hit counts as a use, so it protects that entry from the next eviction.
- R11: A tag is never resident in more than one entry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| lk_valid_i | input | 1 | Lookup request |
| lk_tag_i | input | TAG_W | Lookup tag (PC or page number) |
| lk_hit_o | output | 1 | Lookup tag is resident |
| lk_chips_o | output | 4 | Predicted slice count |
| up_valid_i | input | 1 | Update request |
| up_tag_i | input | TAG_W | Update tag |
| up_real_i | input | 4 | True slice count of the line read |
| up_pred_i | input | 4 | Slice count that was predicted for it |

## Verification
Lookup and update can act in the same cycle. They may name the same tag, or the lookup may hit the very entry that the update would otherwise evict. The bench drives both ports together, in directed steps with the same tag and in a long pseudo-random phase over a tag pool larger than the table. Each lookup answer is judged against a timestamp-based reference table, updated lookup-first, as it stood before the edge.

// File: rtl/sp_pkg.sv
package sp_pkg;
  localparam int unsigned NSZ    = 5;
  localparam int unsigned SZ_W   = $clog2(NSZ);
  localparam int unsigned CHIP_W = 4;
  localparam logic [CHIP_W-1:0] MAX_CHIPS = 4'd9;

  function automatic logic [CHIP_W-1:0] idx_to_chips(input logic [SZ_W-1:0] i);
    case (i)
      3'd0:    return 4'd2;
      3'd1:    return 4'd3;
      3'd2:    return 4'd4;
      3'd3:    return 4'd6;
      default: return 4'd9;
    endcase
  endfunction

  // round up to the next supported size
  function automatic logic [SZ_W-1:0] chips_to_idx(input logic [CHIP_W-1:0] c);
    if (c <= 4'd2)      return 3'd0;
    else if (c == 4'd3) return 3'd1;
    else if (c == 4'd4) return 3'd2;
    else if (c <= 4'd6) return 3'd3;
    else                return 3'd4;
  endfunction
endpackage

// File: rtl/sp_match.sv
module sp_match #(
  parameter int unsigned ENTRIES = 64,
  parameter int unsigned TAG_W   = 32,
  localparam int unsigned IDX_W  = $clog2(ENTRIES)
) (
  input  logic                            en_i,
  input  logic [TAG_W-1:0]                key_i,
  input  logic [ENTRIES-1:0]              valid_i,
  input  logic [ENTRIES-1:0][TAG_W-1:0]   tags_i,
  output logic [ENTRIES-1:0]              vec_o,
  output logic                            hit_o,
  output logic [IDX_W-1:0]                idx_o
);
  for (genvar g = 0; g < ENTRIES; g++) begin : g_cmp
    assign vec_o[g] = en_i & valid_i[g] & (tags_i[g] == key_i);
  end

  assign hit_o = |vec_o;

  // OR encoder, exact while vec_o is one-hot
  always_comb begin
    idx_o = '0;
    for (int j = 0; j < ENTRIES; j++)
      if (vec_o[j]) idx_o = idx_o | IDX_W'(j);
  end
endmodule

// File: rtl/sp_pick.sv
module sp_pick
  import sp_pkg::*;
#(
  parameter int unsigned CNT_W = 2
) (
  input  logic [NSZ-1:0][CNT_W-1:0] cnt_i,
  output logic [SZ_W-1:0]           idx_o
);
  logic [CNT_W-1:0] best;

  // ascending scan with >= so ties land on the larger size
  always_comb begin
    best  = '0;
    idx_o = '0;
    for (int i = 0; i < NSZ; i++)
      if (cnt_i[i] >= best) begin
        best  = cnt_i[i];
        idx_o = SZ_W'(i);
      end
  end
endmodule

// File: rtl/sp_lru.sv
module sp_lru #(
  parameter int unsigned ENTRIES = 64,
  localparam int unsigned IDX_W  = $clog2(ENTRIES)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             a_v_i,
  input  logic [IDX_W-1:0] a_idx_i,
  input  logic             b_v_i,
  input  logic [IDX_W-1:0] b_idx_i,
  output logic [IDX_W-1:0] victim_o
);
  localparam logic [IDX_W-1:0] OLDEST = IDX_W'(ENTRIES - 1);

  // ages form a permutation of 0..ENTRIES-1; never-used entries stay oldest
  logic [ENTRIES-1:0][IDX_W-1:0] age_q, age_a, age_b;

  always_comb begin
    age_a = age_q;
    if (a_v_i)
      for (int j = 0; j < ENTRIES; j++)
        if (IDX_W'(j) == a_idx_i)              age_a[j] = '0;
        else if (age_q[j] < age_q[a_idx_i])    age_a[j] = age_q[j] + IDX_W'(1);
  end

  always_comb begin
    victim_o = '0;
    for (int j = 0; j < ENTRIES; j++)
      if (age_a[j] == OLDEST) victim_o = IDX_W'(j);
  end

  always_comb begin
    age_b = age_a;
    if (b_v_i)
      for (int j = 0; j < ENTRIES; j++)
        if (IDX_W'(j) == b_idx_i)              age_b[j] = '0;
        else if (age_a[j] < age_a[b_idx_i])    age_b[j] = age_a[j] + IDX_W'(1);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)
      for (int j = 0; j < ENTRIES; j++) age_q[j] <= IDX_W'(j);
    else
      age_q <= age_b;
  end
endmodule

// File: rtl/size_pred.sv
module size_pred
  import sp_pkg::*;
#(
  parameter int unsigned TAG_W   = 32,
  parameter int unsigned ENTRIES = 64,
  parameter int unsigned CNT_W   = 2,
  localparam int unsigned IDX_W  = $clog2(ENTRIES)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              lk_valid_i,
  input  logic [TAG_W-1:0]  lk_tag_i,
  output logic              lk_hit_o,
  output logic [CHIP_W-1:0] lk_chips_o,
  input  logic              up_valid_i,
  input  logic [TAG_W-1:0]  up_tag_i,
  input  logic [CHIP_W-1:0] up_real_i,
  input  logic [CHIP_W-1:0] up_pred_i
);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  logic [ENTRIES-1:0]                      valid_q;
  logic [ENTRIES-1:0][TAG_W-1:0]           tag_q;
  logic [ENTRIES-1:0][NSZ-1:0][CNT_W-1:0]  cnt_q;

  logic [ENTRIES-1:0] lk_vec, up_vec;
  logic               up_hit;
  logic [IDX_W-1:0]   lk_idx, up_idx, victim, tgt;
  logic [SZ_W-1:0]    pick_idx, real_idx, pred_idx;
  logic [NSZ-1:0][CNT_W-1:0] new_cnt;

  sp_match #(.ENTRIES(ENTRIES), .TAG_W(TAG_W)) u_lk_match (
    .en_i(lk_valid_i), .key_i(lk_tag_i), .valid_i(valid_q), .tags_i(tag_q),
    .vec_o(lk_vec), .hit_o(lk_hit_o), .idx_o(lk_idx)
  );

  sp_match #(.ENTRIES(ENTRIES), .TAG_W(TAG_W)) u_up_match (
    .en_i(up_valid_i), .key_i(up_tag_i), .valid_i(valid_q), .tags_i(tag_q),
    .vec_o(up_vec), .hit_o(up_hit), .idx_o(up_idx)
  );

  sp_pick #(.CNT_W(CNT_W)) u_pick (.cnt_i(cnt_q[lk_idx]), .idx_o(pick_idx));

  assign lk_chips_o = lk_hit_o ? idx_to_chips(pick_idx) : MAX_CHIPS;

  // lookup touch is applied first, so its entry is never the victim
  sp_lru #(.ENTRIES(ENTRIES)) u_lru (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .a_v_i(lk_hit_o), .a_idx_i(lk_idx),
    .b_v_i(up_valid_i), .b_idx_i(tgt),
    .victim_o(victim)
  );

  assign tgt      = up_hit ? up_idx : victim;
  assign real_idx = chips_to_idx(up_real_i);
  assign pred_idx = chips_to_idx(up_pred_i);

  always_comb begin
    for (int s = 0; s < NSZ; s++) begin
      new_cnt[s] = cnt_q[tgt][s];
      if (!up_hit)
        new_cnt[s] = (SZ_W'(s) == real_idx) ? CNT_W'(1) : '0;
      else if (SZ_W'(s) == real_idx) begin
        if (cnt_q[tgt][s] != CNT_MAX) new_cnt[s] = cnt_q[tgt][s] + CNT_W'(1);
      end else if (SZ_W'(s) == pred_idx) begin
        if (cnt_q[tgt][s] != '0) new_cnt[s] = cnt_q[tgt][s] - CNT_W'(1);
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_q <= '0;
      tag_q   <= '0;
      cnt_q   <= '0;
    end else if (up_valid_i) begin
      valid_q[tgt] <= 1'b1;
      tag_q[tgt]   <= up_tag_i;
      cnt_q[tgt]   <= new_cnt;
    end
  end
endmodule

// File: rtl/size_pred_chk.sv
module size_pred_chk #(
  parameter int unsigned TAG_W   = 32,
  parameter int unsigned ENTRIES = 64
) (
  input logic                          clk_i,
  input logic                          rst_ni,
  input logic                          lk_valid_i,
  input logic                          lk_hit_o,
  input logic [3:0]                    lk_chips_o,
  input logic                          up_valid_i,
  input logic [TAG_W-1:0]              up_tag_i,
  input logic [ENTRIES-1:0]            valid_q,
  input logic [ENTRIES-1:0][TAG_W-1:0] tag_q,
  input logic [ENTRIES-1:0]            lk_vec,
  input logic [ENTRIES-1:0]            up_vec
);
  logic [TAG_W-1:0] up_tag_d;
  logic             present;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) up_tag_d <= '0;
    else         up_tag_d <= up_tag_i;
  end

  always_comb begin
    present = 1'b0;
    for (int j = 0; j < ENTRIES; j++)
      if (valid_q[j] && tag_q[j] == up_tag_d) present = 1'b1;
  end

  a_r2_miss_max: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lk_valid_i && !lk_hit_o) |-> lk_chips_o == 4'd9);

  a_r3_legal_size: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lk_chips_o inside {4'd2, 4'd3, 4'd4, 4'd6, 4'd9});

  a_r4_resident_after_update: assert property (@(posedge clk_i) disable iff (!rst_ni)
    up_valid_i |=> present);

  a_r11_unique_lk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(lk_vec));

  a_r11_unique_up: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(up_vec));

  a_r1_idle_no_hit: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !lk_valid_i |-> !lk_hit_o);
endmodule

bind size_pred size_pred_chk #(.TAG_W(TAG_W), .ENTRIES(ENTRIES)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .lk_valid_i(lk_valid_i), .lk_hit_o(lk_hit_o),
  .lk_chips_o(lk_chips_o), .up_valid_i(up_valid_i), .up_tag_i(up_tag_i),
  .valid_q(valid_q), .tag_q(tag_q), .lk_vec(lk_vec), .up_vec(up_vec)
);

// File: tb/tb_size_pred.sv
`timescale 1ns/1ps
module tb_size_pred;
  localparam int ENT = 64;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        lk_valid_i = 1'b0;
  logic [31:0] lk_tag_i = '0;
  logic        lk_hit_o;
  logic [3:0]  lk_chips_o;
  logic        up_valid_i = 1'b0;
  logic [31:0] up_tag_i = '0;
  logic [3:0]  up_real_i = '0;
  logic [3:0]  up_pred_i = '0;

  size_pred dut (.*);

  always #5 clk_i = ~clk_i;

  int total = 0, bad = 0;
  bit done = 0;

  // reference table: recency by timestamp
  bit          m_val [ENT];
  logic [31:0] m_tag [ENT];
  int          m_cnt [ENT][5];
  int          m_stamp [ENT];
  int          now = 1;
  int          chips_of [5] = '{2, 3, 4, 6, 9};
  logic [31:0] rs = 32'h1234_5678;

  function automatic int size_ix(int c);
    for (int s = 0; s < 5; s++) if (c <= chips_of[s]) return s;
    return 4;
  endfunction

  function automatic int find(logic [31:0] t);
    for (int j = 0; j < ENT; j++) if (m_val[j] && m_tag[j] == t) return j;
    return -1;
  endfunction

  function automatic int expect_chips(int j);
    int bv = -1, bs = 4;
    if (j < 0) return 9;
    for (int s = 4; s >= 0; s--)
      if (m_cnt[j][s] > bv) begin bv = m_cnt[j][s]; bs = s; end
    return chips_of[bs];
  endfunction

  task automatic model_clear();
    for (int j = 0; j < ENT; j++) begin
      m_val[j] = 0; m_stamp[j] = 0;
      for (int s = 0; s < 5; s++) m_cnt[j][s] = 0;
    end
  endtask

  task automatic model_apply(bit lv, logic [31:0] lt, bit uv, logic [31:0] ut, int rc, int pc);
    int j, v, ri, pi;
    if (lv) begin
      j = find(lt);
      if (j >= 0) m_stamp[j] = now;
    end
    now++;
    if (uv) begin
      ri = size_ix(rc); pi = size_ix(pc);
      j = find(ut);
      if (j >= 0) begin
        if (m_cnt[j][ri] < 3) m_cnt[j][ri]++;
        if (pi != ri && m_cnt[j][pi] > 0) m_cnt[j][pi]--;
      end else begin
        v = -1;
        for (int k = 0; k < ENT; k++) if (!m_val[k] && v < 0) v = k;
        if (v < 0) begin
          v = 0;
          for (int k = 1; k < ENT; k++) if (m_stamp[k] < m_stamp[v]) v = k;
        end
        j = v;
        m_val[j] = 1; m_tag[j] = ut;
        for (int s = 0; s < 5; s++) m_cnt[j][s] = (s == ri) ? 1 : 0;
      end
      m_stamp[j] = now;
    end
    now++;
  endtask

  task automatic step(bit lv, logic [31:0] lt, bit uv, logic [31:0] ut, int rc, int pc, string req);
    int j, ec;
    bit eh;
    @(negedge clk_i);
    lk_valid_i = lv; lk_tag_i = lt;
    up_valid_i = uv; up_tag_i = ut; up_real_i = 4'(rc); up_pred_i = 4'(pc);
    #1;
    if (lv) begin
      j = find(lt);
      eh = (j >= 0);
      ec = expect_chips(j);
      total++;
      if (lk_hit_o !== eh || lk_chips_o !== 4'(ec)) begin
        bad++;
        $display("FAIL %s tag=%0d hit=%0b chips=%0d expected hit=%0b chips=%0d",
                 req, lt, lk_hit_o, lk_chips_o, eh, ec);
      end
    end
    @(posedge clk_i);
    model_apply(lv, lt, uv, ut, rc, pc);
  endtask

  task automatic look(logic [31:0] t, string req);
    step(1, t, 0, 0, 0, 0, req);
  endtask

  task automatic upd(logic [31:0] t, int rc, int pc);
    step(0, 0, 1, t, rc, pc, "upd");
  endtask

  task automatic do_reset();
    @(negedge clk_i);
    lk_valid_i = 0; up_valid_i = 0;
    rst_ni = 0;
    model_clear();
    repeat (2) @(negedge clk_i);
    rst_ni = 1;
  endtask

  function automatic logic [31:0] rnd();
    rs = rs ^ (rs << 13); rs = rs ^ (rs >> 17); rs = rs ^ (rs << 5);
    return rs;
  endfunction

  initial begin
    repeat (200000) @(posedge clk_i);
    if (!done) begin
      bad++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    do_reset();
    // R1: empty after reset
    for (int t = 0; t < 4; t++) look(32'(t * 7), "R1");
    // R4: allocation trains the true size
    upd(10, 3, 9);
    look(10, "R4");
    look(11, "R2");
    // R3: rounding of update inputs
    upd(30, 5, 5);  look(30, "R3");
    upd(31, 0, 9);  look(31, "R3");
    upd(32, 12, 2); look(32, "R3");
    upd(33, 7, 7);  look(33, "R3");
    // R7: tie goes to the larger size
    upd(11, 2, 9); upd(11, 4, 4); look(11, "R7");
    // R5: saturation, then R6 pulls the guessed size down
    upd(20, 3, 3);
    for (int k = 0; k < 4; k++) upd(20, 3, 3);
    look(20, "R5");
    for (int k = 0; k < 3; k++) begin upd(20, 9, 3); look(20, "R6"); end
    // R6: decrement stops at zero
    upd(21, 2, 2); upd(21, 4, 6); look(21, "R6");
    upd(21, 6, 6); look(21, "R6");
    // R8: same cycle, same tag
    step(1, 40, 1, 40, 6, 9, "R8");
    look(40, "R8");
    step(1, 40, 1, 40, 4, 6, "R8");
    look(40, "R8");
    // R9/R10: fill the table, protect one entry, force evictions
    do_reset();
    for (int k = 0; k < ENT; k++) upd(32'(100 + k), 4, 4);
    look(100, "R10");
    upd(200, 6, 6);
    look(101, "R9");
    look(100, "R10");
    look(200, "R9");
    // R10: lookup hit in the same cycle as an eviction
    step(1, 102, 1, 201, 2, 2, "R10");
    look(102, "R10");
    look(103, "R9");
    // R11: random mix over a tag pool wider than the table
    for (int k = 0; k < 4000; k++) begin
      logic [31:0] a, b;
      int rc, pc;
      a = rnd(); b = rnd();
      rc = int'(b[3:0]) % 10;
      pc = b[4] ? rc : int'(b[11:8]) % 10;
      step(a[0] | a[1], 32'(a[15:8] % 80), a[2] | a[3], 32'(a[31:24] % 80), rc, pc, "R11");
    end
    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule